// File: doc/BRIEF.md
# State Sequence Occurrence Counter

This block watches the two-bit state value of a four-state machine and counts every time that machine walks through the fixed chain of states 0, 1, 2 and 3 on consecutive enabled samples. It follows partial progress through the chain. A sample that breaks the chain drops the partial progress. If the breaking sample is state 0, that sample opens a new attempt.

A completed chain raises the count by one. The count keeps rising on later completions; it does not stop after the first hit. It saturates at all ones instead of wrapping. A sticky flag and a coverage figure show only whether the chain has been seen at all. The coverage figure is 0 or 100, which is why it is kept separate from the count. The count is a plain register output, so a test environment can read it at any moment, including at the end of a run.

Top module: `seq_occ_mon`

## Requirements
- R1: While rst_ni is low, count_o is 0, seen_o is 0 and cov_pct_o is 0. Reset also discards any partial progress: states sampled before reset never combine with states sampled after it.
- R2: Enabled samples of state codes 0, 1, 2, 3 (state_i encoding 2'd0..2'd3) on consecutive enabled edges raise count_o by exactly one. The increment is visible right after the rising edge that samples code 3.
- R3: Every completion counts. The count keeps rising after the first hit, and no single edge raises it by more than one.
- R4: When en_i is low at a rising edge, state_i is ignored and the progress is held. Disabled cycles inside a chain neither break it nor advance it, and the count does not change.
- R5: An enabled sample that does not continue the chain abandons the partial match. If that sample is code 0, it starts a new match at once.
- R6: After code 3 completes a match, a code 0 on the very next enabled sample begins the next match, with no idle cycle.
- R7: count_o is CNT_W bits wide (default 16) and holds at its all-ones value instead of wrapping.
- R8: seen_o rises with the first completion and stays high until reset. cov_pct_o reads 100 when seen_o is high and 0 otherwise.
- R9: Partial or shifted chains do not count. Examples are 1,2,3, or 0,1,2 followed by anything other than 3, or 0,2,3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample enable |
| state_i | input | 2 | Observed state code of the watched machine |
| count_o | output | CNT_W | Number of completed chains, saturating |
| seen_o | output | 1 | Chain completed at least once |
| cov_pct_o | output | 7 | Coverage figure, 0 or 100 |

## Verification
The bench drives back-to-back chains, where a monitor that needs an idle cycle after a hit would miss the second one. It also drives a chain broken by code 0, where a monitor that returns to idle would lose the restarted match. Disabled cycles are placed inside a chain: a tracker that sampled them would break the chain or skip a step. Reset is applied in the middle of a chain to catch progress that survives reset. A narrowed counter is driven past its limit to catch wrapping to zero.

// File: rtl/seq_occ_mon_pkg.sv
package seq_occ_mon_pkg;
  typedef enum logic [1:0] {
    ST_0 = 2'd0,
    ST_1 = 2'd1,
    ST_2 = 2'd2,
    ST_3 = 2'd3
  } obs_st_e;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_GOT0 = 2'd1,
    TRK_GOT1 = 2'd2,
    TRK_GOT2 = 2'd3
  } trk_e;

  localparam int unsigned PCT_W    = 7;
  localparam int unsigned COV_FULL = 100;
endpackage

// File: rtl/seq_tracker.sv
module seq_tracker
  import seq_occ_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] state_i,
  output logic       hit_o
);
  trk_e    trk_q, trk_d;
  obs_st_e st;

  assign st = obs_st_e'(state_i);

  always_comb begin
    trk_d = trk_q;
    hit_o = 1'b0;
    if (en_i) begin
      unique case (trk_q)
        TRK_GOT0: trk_d = (st == ST_1) ? TRK_GOT1 : ((st == ST_0) ? TRK_GOT0 : TRK_IDLE);
        TRK_GOT1: trk_d = (st == ST_2) ? TRK_GOT2 : ((st == ST_0) ? TRK_GOT0 : TRK_IDLE);
        TRK_GOT2: begin
          // completion returns to idle so a following ST_0 opens the next match
          hit_o = (st == ST_3);
          trk_d = (st == ST_0) ? TRK_GOT0 : TRK_IDLE;
        end
        default:  trk_d = (st == ST_0) ? TRK_GOT0 : TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trk_q <= TRK_IDLE;
    else         trk_q <= trk_d;
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cov_flag.sv
module cov_flag
  import seq_occ_mon_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  output logic             seen_o,
  output logic [PCT_W-1:0] pct_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_o <= 1'b0;
    else if (hit_i) seen_o <= 1'b1;
  end

  assign pct_o = seen_o ? PCT_W'(COV_FULL) : '0;
endmodule

// File: rtl/seq_occ_mon.sv
module seq_occ_mon
  import seq_occ_mon_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       state_i,
  output logic [CNT_W-1:0] count_o,
  output logic             seen_o,
  output logic [PCT_W-1:0] cov_pct_o
);
  logic hit;

  seq_tracker u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .state_i (state_i),
    .hit_o   (hit)
  );

  sat_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (hit),
    .cnt_o  (count_o)
  );

  cov_flag u_cov (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .seen_o (seen_o),
    .pct_o  (cov_pct_o)
  );
endmodule

// File: rtl/seq_occ_mon_chk.sv
module seq_occ_mon_chk
  import seq_occ_mon_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       state_i,
  input logic [CNT_W-1:0] count_o,
  input logic             seen_o,
  input logic [PCT_W-1:0] cov_pct_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !seen_o && cov_pct_o == '0)); // R1

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1)); // R3

  AST_HIT_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0 && count_o != MAX && !(en_i && state_i == 2'd3)) |=> $stable(count_o)); // R2

  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_o)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == MAX) |=> (count_o == MAX)); // R7

  AST_SEEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_o |=> seen_o); // R8

  AST_SEEN_VS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) == seen_o); // R8
endmodule

bind seq_occ_mon seq_occ_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .state_i   (state_i),
  .count_o   (count_o),
  .seen_o    (seen_o),
  .cov_pct_o (cov_pct_o)
);

// File: tb/seq_occ_mon_test.sv
`timescale 1ns/1ps
module seq_occ_mon_test;
  localparam int unsigned CNT_W = 6;
  localparam int unsigned NVEC  = 27;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [1:0]       st = 2'd0;
  logic [CNT_W-1:0] cnt;
  logic             seen;
  logic [6:0]       pct;
  int               n_chk = 0;
  int               n_bad = 0;

  always #2 clk = ~clk;

  seq_occ_mon #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .state_i(st),
    .count_o(cnt), .seen_o(seen), .cov_pct_o(pct)
  );

  // {en, state, expected count, expected seen}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 8'd0, 1'b0}, {1'b1, 2'd1, 8'd0, 1'b0}, {1'b1, 2'd2, 8'd0, 1'b0},
    {1'b1, 2'd3, 8'd1, 1'b1},                                   // R2
    {1'b1, 2'd0, 8'd1, 1'b1}, {1'b1, 2'd1, 8'd1, 1'b1}, {1'b1, 2'd2, 8'd1, 1'b1},
    {1'b1, 2'd3, 8'd2, 1'b1},                                   // R6 R3
    {1'b1, 2'd1, 8'd2, 1'b1}, {1'b1, 2'd2, 8'd2, 1'b1}, {1'b1, 2'd3, 8'd2, 1'b1}, // R9
    {1'b1, 2'd0, 8'd2, 1'b1}, {1'b1, 2'd1, 8'd2, 1'b1},
    {1'b1, 2'd0, 8'd2, 1'b1},                                   // R5 restart
    {1'b1, 2'd1, 8'd2, 1'b1}, {1'b1, 2'd2, 8'd2, 1'b1}, {1'b1, 2'd3, 8'd3, 1'b1},
    {1'b1, 2'd0, 8'd3, 1'b1}, {1'b0, 2'd3, 8'd3, 1'b1},         // R4
    {1'b1, 2'd1, 8'd3, 1'b1}, {1'b0, 2'd0, 8'd3, 1'b1},
    {1'b1, 2'd2, 8'd3, 1'b1}, {1'b1, 2'd3, 8'd4, 1'b1},
    {1'b1, 2'd0, 8'd4, 1'b1}, {1'b1, 2'd2, 8'd4, 1'b1},         // R9 skipped step
    {1'b1, 2'd3, 8'd4, 1'b1}, {1'b1, 2'd3, 8'd4, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [1:0] s);
    en = e;
    st = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    en = 1'b0;
    #1;
    chk("R1", "count in reset", int'(cnt), 0);
    chk("R1", "seen in reset", int'(seen), 0);
    chk("R1", "cov in reset", int'(pct), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic chain(input int n);
    for (int k = 0; k < n; k++) begin
      step(1'b1, 2'd0); step(1'b1, 2'd1); step(1'b1, 2'd2); step(1'b1, 2'd3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][11], VEC[i][10:9]);
      chk("R2-R6-R9", $sformatf("vec %0d count", i), int'(cnt), int'(VEC[i][8:1]));
      chk("R8", $sformatf("vec %0d seen", i), int'(seen), int'(VEC[i][0]));
      chk("R8", $sformatf("vec %0d cov", i), int'(pct), VEC[i][0] ? 100 : 0);
    end

    // R1: reset in the middle of a chain drops progress
    step(1'b1, 2'd0);
    step(1'b1, 2'd1);
    do_reset();
    step(1'b1, 2'd2);
    step(1'b1, 2'd3);
    chk("R1", "count after mid-chain reset", int'(cnt), 0);
    chk("R8", "cov before any hit", int'(pct), 0);
    chain(1);
    chk("R2", "count after fresh chain", int'(cnt), 1);

    // R7: saturation of the narrowed counter
    do_reset();
    chain(62);
    chk("R3", "count after 62 chains", int'(cnt), 62);
    chain(1);
    chk("R7", "count at limit", int'(cnt), 63);
    chain(5);
    chk("R7", "count held at limit", int'(cnt), 63);
    chk("R8", "seen held", int'(seen), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule